// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries an 8/16-bit processor into an exception handler. It collects the hardware requests (reset, abort, a falling-edge non-maskable line, a maskable interrupt) and the two software traps (break and coprocessor). It picks one of them by fixed priority and then drives the processor bus for one cycle per clock. During those cycles it stores the return context on a downward-growing stack and fetches a two-byte handler address. When the sequence ends it hands the core the new program counter, status byte, program bank, stack pointer and mode flag.

The core gives the block its live context: the current PC, bank, stack pointer, status byte, emulation flag and the address of the faulting opcode. It uses the results when `done` pulses. No data stream has a handshake here. Every bus cycle finishes in one clock, so the memory must return `bus_rdata` in the same cycle as the address. The block never waits, and it cannot be back-pressured. All other pins are plain control and status signals.

Top module: `exc_entry_seq`

## Requirements
- R1: Requests are sampled only at a clock edge where `busy` is low. The winner is chosen in this order: reset, abort, non-maskable, maskable, break, coprocessor. The maskable request is taken only while status bit 2 (interrupt disable) of `p_in` is 0. A request that loses arbitration while the block is idle does not start its own sequence, except for a pending non-maskable request.
- R2: A hardware entry opens with two cycles at `{pb_in, pc_in}` with `bus_rw`=1 and `bus_vp`=1. The first cycle has SYNC=VDA=VPA=1. The second has SYNC=VDA=VPA=0.
- R3: A software entry opens with an opcode cycle at `{pb_in, pc_in-2}` with SYNC=VDA=VPA=1. It is followed by a signature cycle at `{pb_in, pc_in-1}` with VPA=1 and SYNC=VDA=0. Both cycles have R/W=1 and VP=1.
- R4: In native mode the block makes four push cycles in this order: bank, PC high byte, PC low byte, status. Each push uses address `{8'h00, SP}` with R/W=0, VDA=1, VPA=0, SYNC=0 and VP=1. SP then drops by one.
- R5: In emulation mode (`emu_in`=1) the bank push is left out, so the sequence lasts 7 cycles instead of 8.
- R6: For a hardware source in emulation mode, bit 4 of the stored status byte is written as 0. Software sources store `p_in` unchanged.
- R7: Reset runs the push cycles with R/W held at 1, and SP still steps down once per push. Reset always uses the 7-cycle emulation sequence and reports `new_emu`=1.
- R8: For abort, the PC bytes pushed are `abort_pc`, not `pc_in`.
- R9: The last two cycles read the vector low byte and then the high byte at `{8'h00, V}` and `{8'h00, V+1}` with R/W=1, VDA=1, VPA=0, SYNC=0 and VP=0. V is given as emulation/native: reset FFFC/FFFC, abort FFF8/FFE8, non-maskable FFFA/FFEA, maskable FFFE/FFEE, break FFFE/FFE6, coprocessor FFF4/FFE4.
- R10: `done` is high for exactly one cycle, in the cycle after the high-byte read. While it is high, `new_pc` = {high byte, low byte}, `new_p` = the accepted status with bit 3 cleared and bit 2 set, `new_pb` = 0, and `new_sp` = the stack pointer after the pushes.
- R11: A falling edge on `nmi_n` is held pending until its sequence starts. A line that simply stays low does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| req_reset | input | 1 | Processor reset request |
| req_abort | input | 1 | Abort request |
| nmi_n | input | 1 | Non-maskable line, active on its falling edge |
| req_irq | input | 1 | Maskable interrupt level |
| req_brk | input | 1 | Break trap request |
| req_cop | input | 1 | Coprocessor trap request |
| emu_in | input | 1 | Current emulation-mode flag |
| pc_in | input | 16 | Current program counter (next instruction for hardware, after signature for traps) |
| pb_in | input | 8 | Current program bank |
| sp_in | input | 16 | Current stack pointer |
| p_in | input | 8 | Current status byte |
| abort_pc | input | 16 | Address of the aborted opcode |
| bus_rdata | input | 8 | Read data, valid in the same cycle |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_sync | output | 1 | Opcode-fetch marker |
| bus_vda | output | 1 | Valid data address |
| bus_vpa | output | 1 | Valid program address |
| bus_vp | output | 1 | Low during vector fetch |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Handler address |
| new_p | output | 8 | Updated status byte |
| new_pb | output | 8 | Updated program bank |
| new_sp | output | 16 | Updated stack pointer |
| new_emu | output | 1 | Updated emulation flag |

## Verification
A request present at an idle clock edge produces its first bus cycle in the very next cycle. After that, one bus cycle is due per clock. The `done` pulse comes 8 cycles after the accepting edge in emulation mode and 9 cycles after it in native mode. The bench works out this exact cycle list when it raises a request and places it in a queue. A monitor then compares bus pins on every busy cycle and results on every `done` cycle, sampling on the falling clock edge. A cycle that is missing, extra or shifted therefore shows up as a mismatch at the position where it occurs. Windows where the block must stay idle are checked cycle by cycle on `busy` and `done`.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    SRC_RESET,
    SRC_ABORT,
    SRC_NMI,
    SRC_IRQ,
    SRC_BRK,
    SRC_COP
  } exc_src_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD1,
    ST_LEAD2,
    ST_PUSH_BANK,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_STAT,
    ST_VEC_LO,
    ST_VEC_HI
  } exc_state_e;

  function automatic logic src_is_hw(exc_src_e s);
    return (s != SRC_BRK) && (s != SRC_COP);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int I_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              req_reset,
  input  logic              req_abort,
  input  logic              nmi_n,
  input  logic              req_irq,
  input  logic              req_brk,
  input  logic              req_cop,
  input  logic [DATA_W-1:0] status,
  output logic              grant,
  output exc_src_e          grant_src
);

  logic nmi_q;
  logic nmi_pend;
  logic nmi_hit;
  logic irq_ok;
  logic take_nmi;

  assign nmi_hit = nmi_pend | (nmi_q & ~nmi_n);
  assign irq_ok  = req_irq & ~status[I_BIT];

  always_comb begin
    grant     = idle;
    grant_src = SRC_RESET;
    if (req_reset)      grant_src = SRC_RESET;
    else if (req_abort) grant_src = SRC_ABORT;
    else if (nmi_hit)   grant_src = SRC_NMI;
    else if (irq_ok)    grant_src = SRC_IRQ;
    else if (req_brk)   grant_src = SRC_BRK;
    else if (req_cop)   grant_src = SRC_COP;
    else                grant     = 1'b0;
  end

  assign take_nmi = grant && (grant_src == SRC_NMI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= nmi_hit & ~take_nmi;
    end
  end

endmodule

// File: rtl/exc_vector_table.sv
module exc_vector_table
  import exc_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] EMU_BASE = 16'hFFF0,
  parameter logic [PC_W-1:0] NAT_BASE = 16'hFFE0
) (
  input  exc_src_e        src,
  input  logic            emu,
  output logic [PC_W-1:0] vec
);

  logic [3:0] off_emu;
  logic [3:0] off_nat;
  logic       use_emu;

  always_comb begin
    unique case (src)
      SRC_RESET: begin off_emu = 4'hC; off_nat = 4'hC; end
      SRC_ABORT: begin off_emu = 4'h8; off_nat = 4'h8; end
      SRC_NMI:   begin off_emu = 4'hA; off_nat = 4'hA; end
      SRC_IRQ:   begin off_emu = 4'hE; off_nat = 4'hE; end
      SRC_BRK:   begin off_emu = 4'hE; off_nat = 4'h6; end
      SRC_COP:   begin off_emu = 4'h4; off_nat = 4'h4; end
      default:   begin off_emu = 4'hC; off_nat = 4'hC; end
    endcase
  end

  // The reset handler address lives in the emulation page for both modes.
  assign use_emu = emu || (src == SRC_RESET);
  assign vec = use_emu ? (EMU_BASE | PC_W'(off_emu)) : (NAT_BASE | PC_W'(off_nat));

endmodule

// File: rtl/exc_cycle_fsm.sv
module exc_cycle_fsm
  import exc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8,
  parameter int I_BIT  = 2,
  parameter int D_BIT  = 3,
  parameter int B_BIT  = 4,
  localparam int ADDR_W = BANK_W + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  exc_src_e          grant_src,
  input  logic              emu_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BANK_W-1:0] pb_in,
  input  logic [PC_W-1:0]   sp_in,
  input  logic [DATA_W-1:0] p_in,
  input  logic [PC_W-1:0]   abort_pc,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [PC_W-1:0]   vec,
  output exc_src_e          cur_src,
  output logic              cur_emu,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rw,
  output logic              bus_sync,
  output logic              bus_vda,
  output logic              bus_vpa,
  output logic              bus_vp,
  output logic              busy,
  output logic              done,
  output logic [PC_W-1:0]   new_pc,
  output logic [DATA_W-1:0] new_p,
  output logic [BANK_W-1:0] new_pb,
  output logic [PC_W-1:0]   new_sp,
  output logic              new_emu
);

  exc_state_e        state, state_nx;
  logic [PC_W-1:0]   fetch_pc_q;
  logic [PC_W-1:0]   ret_pc_q;
  logic [BANK_W-1:0] pb_q;
  logic [PC_W-1:0]   sp_q;
  logic [DATA_W-1:0] p_q;
  logic [DATA_W-1:0] lo_q;
  logic              hw;
  logic              pushing;
  logic              accept;

  assign hw      = src_is_hw(cur_src);
  assign busy    = (state != ST_IDLE);
  assign accept  = (state == ST_IDLE) && grant;
  assign pushing = (state == ST_PUSH_BANK) || (state == ST_PUSH_HI) ||
                   (state == ST_PUSH_LO)   || (state == ST_PUSH_STAT);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:      if (grant) state_nx = ST_LEAD1;
      ST_LEAD1:     state_nx = ST_LEAD2;
      ST_LEAD2:     state_nx = cur_emu ? ST_PUSH_HI : ST_PUSH_BANK;
      ST_PUSH_BANK: state_nx = ST_PUSH_HI;
      ST_PUSH_HI:   state_nx = ST_PUSH_LO;
      ST_PUSH_LO:   state_nx = ST_PUSH_STAT;
      ST_PUSH_STAT: state_nx = ST_VEC_LO;
      ST_VEC_LO:    state_nx = ST_VEC_HI;
      ST_VEC_HI:    state_nx = ST_IDLE;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_src    <= SRC_RESET;
      cur_emu    <= 1'b1;
      fetch_pc_q <= '0;
      ret_pc_q   <= '0;
      pb_q       <= '0;
      sp_q       <= '0;
      p_q        <= '0;
      lo_q       <= '0;
      done       <= 1'b0;
      new_pc     <= '0;
      new_p      <= '0;
      new_pb     <= '0;
      new_sp     <= '0;
      new_emu    <= 1'b1;
    end else begin
      state <= state_nx;
      done  <= (state == ST_VEC_HI);
      if (accept) begin
        cur_src    <= grant_src;
        cur_emu    <= emu_in || (grant_src == SRC_RESET);
        fetch_pc_q <= pc_in;
        ret_pc_q   <= (grant_src == SRC_ABORT) ? abort_pc : pc_in;
        pb_q       <= pb_in;
        sp_q       <= sp_in;
        p_q        <= p_in;
      end
      if (pushing) sp_q <= sp_q - PC_W'(1);
      if (state == ST_VEC_LO) lo_q <= bus_rdata;
      if (state == ST_VEC_HI) begin
        new_pc  <= PC_W'({bus_rdata, lo_q});
        new_p   <= (p_q & ~(DATA_W'(1) << D_BIT)) | (DATA_W'(1) << I_BIT);
        new_pb  <= '0;
        new_sp  <= sp_q;
        new_emu <= cur_emu;
      end
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_rw    = 1'b1;
    bus_sync  = 1'b0;
    bus_vda   = 1'b0;
    bus_vpa   = 1'b0;
    bus_vp    = 1'b1;
    unique case (state)
      ST_LEAD1: begin
        bus_addr = {pb_q, hw ? fetch_pc_q : fetch_pc_q - PC_W'(2)};
        bus_sync = 1'b1;
        bus_vda  = 1'b1;
        bus_vpa  = 1'b1;
      end
      ST_LEAD2: begin
        bus_addr = {pb_q, hw ? fetch_pc_q : fetch_pc_q - PC_W'(1)};
        bus_vpa  = ~hw;
      end
      ST_PUSH_BANK, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_STAT: begin
        bus_addr = {BANK_W'(0), sp_q};
        bus_vda  = 1'b1;
        bus_rw   = (cur_src == SRC_RESET);
        if (state == ST_PUSH_BANK)    bus_wdata = DATA_W'(pb_q);
        else if (state == ST_PUSH_HI) bus_wdata = DATA_W'(ret_pc_q >> DATA_W);
        else if (state == ST_PUSH_LO) bus_wdata = DATA_W'(ret_pc_q);
        else bus_wdata = (hw && cur_emu) ? (p_q & ~(DATA_W'(1) << B_BIT)) : p_q;
      end
      ST_VEC_LO, ST_VEC_HI: begin
        bus_addr = {BANK_W'(0), (state == ST_VEC_HI) ? vec + PC_W'(1) : vec};
        bus_vda  = 1'b1;
        bus_vp   = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8,
  parameter logic [PC_W-1:0] EMU_BASE = 16'hFFF0,
  parameter logic [PC_W-1:0] NAT_BASE = 16'hFFE0,
  localparam int ADDR_W = BANK_W + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_abort,
  input  logic              nmi_n,
  input  logic              req_irq,
  input  logic              req_brk,
  input  logic              req_cop,
  input  logic              emu_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BANK_W-1:0] pb_in,
  input  logic [PC_W-1:0]   sp_in,
  input  logic [DATA_W-1:0] p_in,
  input  logic [PC_W-1:0]   abort_pc,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rw,
  output logic              bus_sync,
  output logic              bus_vda,
  output logic              bus_vpa,
  output logic              bus_vp,
  output logic              busy,
  output logic              done,
  output logic [PC_W-1:0]   new_pc,
  output logic [DATA_W-1:0] new_p,
  output logic [BANK_W-1:0] new_pb,
  output logic [PC_W-1:0]   new_sp,
  output logic              new_emu
);

  logic            grant;
  exc_src_e        grant_src;
  exc_src_e        cur_src;
  logic            cur_emu;
  logic [PC_W-1:0] vec;

  exc_arbiter #(.DATA_W(DATA_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (~busy),
    .req_reset (req_reset),
    .req_abort (req_abort),
    .nmi_n     (nmi_n),
    .req_irq   (req_irq),
    .req_brk   (req_brk),
    .req_cop   (req_cop),
    .status    (p_in),
    .grant     (grant),
    .grant_src (grant_src)
  );

  exc_vector_table #(.PC_W(PC_W), .EMU_BASE(EMU_BASE), .NAT_BASE(NAT_BASE)) u_vec (
    .src (cur_src),
    .emu (cur_emu),
    .vec (vec)
  );

  exc_cycle_fsm #(.PC_W(PC_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .grant_src (grant_src),
    .emu_in    (emu_in),
    .pc_in     (pc_in),
    .pb_in     (pb_in),
    .sp_in     (sp_in),
    .p_in      (p_in),
    .abort_pc  (abort_pc),
    .bus_rdata (bus_rdata),
    .vec       (vec),
    .cur_src   (cur_src),
    .cur_emu   (cur_emu),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rw    (bus_rw),
    .bus_sync  (bus_sync),
    .bus_vda   (bus_vda),
    .bus_vpa   (bus_vpa),
    .bus_vp    (bus_vp),
    .busy      (busy),
    .done      (done),
    .new_pc    (new_pc),
    .new_p     (new_p),
    .new_pb    (new_pb),
    .new_sp    (new_sp),
    .new_emu   (new_emu)
  );

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
  import exc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BANK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rw,
  input logic              bus_sync,
  input logic              bus_vda,
  input logic              bus_vpa,
  input logic              bus_vp,
  input logic              busy,
  input logic              done,
  input exc_src_e          cur_src
);

  p_push_is_data_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rw |-> (bus_vda && !bus_vpa && !bus_sync && bus_vp && busy));

  p_reset_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_src == SRC_RESET) |-> bus_rw);

  p_vector_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vp |-> (bus_rw && bus_vda && !bus_vpa && !bus_sync &&
                 bus_addr[ADDR_W-1 -: BANK_W] == '0));

  p_opcode_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sync |-> (bus_vda && bus_vpa && bus_rw && bus_vp));

  p_done_after_vec_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_vp && bus_addr[0]) |=> (done && !busy));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_rw && !bus_vda && !bus_vpa && bus_vp));

endmodule

bind exc_entry_seq exc_entry_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_rw   (bus_rw),
  .bus_sync (bus_sync),
  .bus_vda  (bus_vda),
  .bus_vpa  (bus_vpa),
  .bus_vp   (bus_vp),
  .busy     (busy),
  .done     (done),
  .cur_src  (cur_src)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n, req_reset, req_abort, nmi_n, req_irq, req_brk, req_cop, emu_in;
  logic [15:0] pc_in, sp_in, abort_pc;
  logic [7:0]  pb_in, p_in, bus_rdata;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rw, bus_sync, bus_vda, bus_vpa, bus_vp, busy, done;
  logic [15:0] new_pc, new_sp;
  logic [7:0]  new_p, new_pb;
  logic        new_emu;

  assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

  exc_entry_seq dut (.*);

  typedef struct {
    bit          is_res;
    logic [23:0] addr;
    logic [4:0]  ctl;
    logic [7:0]  wd;
    bit          chk_wd;
    logic [15:0] npc;
    logic [7:0]  np;
    logic [15:0] nsp;
    bit          nemu;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_chk  = 0;
  int   n_fail = 0;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] vec_of(input int src, input bit e);
    case (src)
      0: return 16'hFFFC;
      1: return e ? 16'hFFF8 : 16'hFFE8;
      2: return e ? 16'hFFFA : 16'hFFEA;
      3: return e ? 16'hFFFE : 16'hFFEE;
      4: return e ? 16'hFFFE : 16'hFFE6;
      default: return e ? 16'hFFF4 : 16'hFFE4;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic push_bus(input logic [23:0] a, input logic [4:0] c, input logic [7:0] d,
                          input bit cw, input string tag);
    exp_t x;
    x.is_res = 0; x.addr = a; x.ctl = c; x.wd = d; x.chk_wd = cw; x.tag = tag;
    x.npc = '0; x.np = '0; x.nsp = '0; x.nemu = 0;
    q.push_back(x);
  endtask

  // ctl bits: {rw, sync, vda, vpa, vp}
  task automatic expect_entry(input int src, input bit emu, input logic [15:0] pc,
                              input logic [7:0] pb, input logic [15:0] sp,
                              input logic [7:0] p, input logic [15:0] apc);
    bit          e   = emu || (src == 0);
    bit          hw  = (src < 4);
    bit          rw  = (src == 0);
    logic [15:0] s   = sp;
    logic [15:0] ret = (src == 1) ? apc : pc;
    logic [15:0] v   = vec_of(src, e);
    logic [7:0]  pv  = (hw && e) ? (p & 8'hEF) : p;
    string       pt  = (src == 0) ? "R7" : (src == 1) ? "R8" : e ? "R5" : "R4";
    exp_t        r;
    if (hw) begin
      push_bus({pb, pc}, 5'b11111, 8'h00, 0, "R2");
      push_bus({pb, pc}, 5'b10001, 8'h00, 0, "R2");
    end else begin
      push_bus({pb, pc - 16'd2}, 5'b11111, 8'h00, 0, "R3");
      push_bus({pb, pc - 16'd1}, 5'b10011, 8'h00, 0, "R3");
    end
    if (!e) begin
      push_bus({8'h00, s}, {rw, 4'b0101}, pb, 1, "R4");
      s = s - 16'd1;
    end
    push_bus({8'h00, s}, {rw, 4'b0101}, ret[15:8], 1, pt); s = s - 16'd1;
    push_bus({8'h00, s}, {rw, 4'b0101}, ret[7:0], 1, pt);  s = s - 16'd1;
    push_bus({8'h00, s}, {rw, 4'b0101}, pv, 1, (hw && e) ? "R6" : pt); s = s - 16'd1;
    push_bus({8'h00, v}, 5'b10100, 8'h00, 0, "R9");
    push_bus({8'h00, v + 16'd1}, 5'b10100, 8'h00, 0, "R9");
    r.is_res = 1; r.addr = '0; r.ctl = '0; r.wd = '0; r.chk_wd = 0;
    r.npc = {mem(v + 16'd1), mem(v)};
    r.np = (p & 8'hF7) | 8'h04; r.nsp = s; r.nemu = e; r.tag = "R10";
    q.push_back(r);
  endtask

  // Monitor: one expected item per busy cycle and per done pulse.
  always @(negedge clk) begin
    if (rst_n && (busy || done)) begin
      if (q.size() == 0) begin
        check(0, "R1 unexpected activity", {63'd0, busy}, 64'd0);
      end else begin
        cur = q.pop_front();
        if (cur.is_res) begin
          check(done && !busy && new_pc == cur.npc && new_p == cur.np &&
                new_pb == 8'h00 && new_sp == cur.nsp && new_emu == cur.nemu, cur.tag,
                {7'd0, done, new_emu, new_pc, new_p, new_pb, new_sp},
                {7'd0, 1'b1, cur.nemu, cur.npc, cur.np, 8'h00, cur.nsp});
        end else begin
          check(busy && bus_addr == cur.addr &&
                {bus_rw, bus_sync, bus_vda, bus_vpa, bus_vp} == cur.ctl &&
                (!cur.chk_wd || bus_wdata == cur.wd), cur.tag,
                {19'd0, busy, bus_addr, 3'd0, bus_rw, bus_sync, bus_vda, bus_vpa, bus_vp,
                 cur.chk_wd ? bus_wdata : 8'h00},
                {19'd0, 1'b1, cur.addr, 3'd0, cur.ctl, cur.chk_wd ? cur.wd : 8'h00});
        end
      end
    end
  end

  task automatic kick();
    @(posedge clk);
    @(negedge clk);
    req_reset = 0; req_abort = 0; req_brk = 0; req_cop = 0;
  endtask

  task automatic drain();
    int i = 0;
    while (q.size() != 0 && i < 60) begin
      @(negedge clk);
      i++;
    end
    if (q.size() != 0) begin
      check(0, "R10 sequence incomplete", 64'(q.size()), 64'd0);
      q.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_window(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!busy && !done, tag, {62'd0, busy, done}, 64'd0);
    end
  endtask

  task automatic set_ctx(input bit e, input logic [15:0] pc, input logic [7:0] pb,
                         input logic [15:0] sp, input logic [7:0] p, input logic [15:0] apc);
    emu_in = e; pc_in = pc; pb_in = pb; sp_in = sp; p_in = p; abort_pc = apc;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    rst_n = 0; req_reset = 0; req_abort = 0; nmi_n = 1; req_irq = 0; req_brk = 0; req_cop = 0;
    set_ctx(0, 16'h0000, 8'h00, 16'h01FF, 8'h00, 16'h0000);
    repeat (3) @(negedge clk);
    check(!busy && !done && bus_rw && bus_vp && !bus_vda, "R1 reset state",
          {59'd0, busy, done, bus_rw, bus_vp, bus_vda}, {59'd0, 5'b00110});
    rst_n = 1;
    @(negedge clk);

    // Native maskable entry: R2, R4, R9, R10
    set_ctx(0, 16'h1234, 8'h12, 16'h01FF, 8'h00, 16'h0000);
    req_irq = 1;
    expect_entry(3, 0, 16'h1234, 8'h12, 16'h01FF, 8'h00, 16'h0000);
    @(posedge clk); @(negedge clk); req_irq = 0;
    drain();

    // Emulation maskable entry: R5, R6 (bit 4 stored as 0)
    set_ctx(1, 16'h2345, 8'h00, 16'h01F0, 8'h30, 16'h0000);
    req_irq = 1;
    expect_entry(3, 1, 16'h2345, 8'h00, 16'h01F0, 8'h30, 16'h0000);
    @(posedge clk); @(negedge clk); req_irq = 0;
    drain();

    // Native break trap: R3
    set_ctx(0, 16'h8003, 8'h7E, 16'h0345, 8'h10, 16'h0000);
    req_brk = 1;
    expect_entry(4, 0, 16'h8003, 8'h7E, 16'h0345, 8'h10, 16'h0000);
    kick(); drain();

    // Emulation coprocessor trap: status stored unchanged (R6), 7 cycles (R5)
    set_ctx(1, 16'h0402, 8'h00, 16'h01C0, 8'h10, 16'h0000);
    req_cop = 1;
    expect_entry(5, 1, 16'h0402, 8'h00, 16'h01C0, 8'h10, 16'h0000);
    kick(); drain();

    // Abort beats NMI and break (R1, R8); the NMI edge stays pending (R11)
    set_ctx(0, 16'h5555, 8'h03, 16'h0200, 8'h00, 16'h4444);
    req_abort = 1; req_brk = 1; nmi_n = 0;
    expect_entry(1, 0, 16'h5555, 8'h03, 16'h0200, 8'h00, 16'h4444);
    expect_entry(2, 0, 16'h5555, 8'h03, 16'h0200, 8'h00, 16'h4444);
    kick(); drain();
    idle_window(6, "R11 held-low line must not retrigger");
    nmi_n = 1;
    @(negedge clk);

    // Reset beats a masked maskable request; writes suppressed (R7)
    set_ctx(0, 16'h0600, 8'h05, 16'h0180, 8'h04, 16'h0000);
    req_reset = 1; req_irq = 1;
    expect_entry(0, 0, 16'h0600, 8'h05, 16'h0180, 8'h04, 16'h0000);
    kick(); drain();
    idle_window(6, "R1 masked maskable request ignored");
    req_irq = 0;

    // Emulation NMI via a fresh falling edge
    set_ctx(1, 16'h0777, 8'h00, 16'h01FF, 8'h01, 16'h0000);
    nmi_n = 0;
    expect_entry(2, 1, 16'h0777, 8'h00, 16'h01FF, 8'h01, 16'h0000);
    kick(); drain();
    nmi_n = 1;
    idle_window(3, "R11 no activity after release");

    finish_run();
  end

endmodule